// File: doc/BRIEF.md
# Two-Level Page Table Walker

This unit turns a 32-bit virtual address into a 30-bit physical address by walking a two-level tree of translation tables held in memory. A software-managed root register points at the top-level table. The top-level entry chosen by the high address bits gives the base of a second-level table. The second-level entry chosen by the middle bits gives the physical page number, which is joined to the untranslated page offset.

The processor side uses a valid/ready request and a response that is held until it is accepted. The memory side is a single read port with a request/ready address phase and a separate data-valid return. Each translation makes two dependent reads on that port, because the second read address is built from the data of the first. Only one walk is in flight at a time. A clear present flag in either entry ends the walk early with a fault response.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `rsp_valid` and `mem_req` are 0.
- R2: The virtual address splits as top-level index = bits 31:20 (12 bits), second-level index = bits 19:12 (8 bits) and page offset = bits 11:0.
- R3: The first read address is root + 4 × top-level index, taken modulo 2^30.
- R4: The second read address is bits 29:0 of the top-level entry + 4 × second-level index, modulo 2^30. It is requested only after the top-level data has returned.
- R5: On success, `rsp_fault` is 0 and `rsp_pa` = {second-level entry bits 17:0, page offset}.
- R6: If bit 31 (present) of the top-level entry is 0, the response has `rsp_fault` = 1 and no second read is requested.
- R7: If bit 31 (present) of the second-level entry is 0, the response has `rsp_fault` = 1.
- R8: Once `mem_req` rises, it stays high with `mem_addr` unchanged until a cycle in which `mem_ready` is 1.
- R9: `req_ready` is 1 only while no walk is in progress. `rsp_valid` stays high with a stable response until `rsp_ready` is 1, and `req_ready` returns in the next cycle.
- R10: A root write (`root_we`) while idle is used by the next walk. A root write during a walk is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_we | input | 1 | Root pointer write strobe |
| root_wdata | input | 30 | New root pointer (top-level table base) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Result accepted |
| rsp_pa | output | 30 | Physical address |
| rsp_fault | output | 1 | A table entry was not present |
| mem_req | output | 1 | Memory read request |
| mem_ready | input | 1 | Memory accepts the read address |
| mem_addr | output | 30 | Memory read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data (one table entry) |

## Verification
Random virtual addresses, roots and entries, with random address-phase stalls and data latencies, check the arithmetic at both levels against independently computed addresses. The stalls separate a held request from a re-issued one. Directed cases use an all-zero address, an all-ones address and a root near the top of the space. Together they expose field-boundary slips and missing modulo wrap in the adders. A missing top-level entry, a missing second-level entry and a root write arriving mid-walk separate the two fault exits from each other and show whether the root is locked during a walk.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_L1_REQ  = 3'd1,
      ST_L1_WAIT = 3'd2,
      ST_L2_REQ  = 3'd3,
      ST_L2_WAIT = 3'd4,
      ST_DONE    = 3'd5
   } walk_state_t;

endpackage

// File: rtl/ptw_field_split.sv
module ptw_field_split #(
   parameter int VA_W  = 32,
   parameter int L1_W  = 12,
   parameter int L2_W  = 8,
   parameter int OFF_W = 12
) (
   input  logic [VA_W-1:0]  va,
   output logic [L1_W-1:0]  l1_idx,
   output logic [L2_W-1:0]  l2_idx,
   output logic [OFF_W-1:0] offset
);
   localparam int L2_LO = OFF_W;
   localparam int L1_LO = OFF_W + L2_W;

   if (L1_W + L2_W + OFF_W != VA_W) begin : g_bad_split
      $error("field widths must sum to the virtual address width");
   end

   assign offset = va[OFF_W-1:0];
   assign l2_idx = va[L1_LO-1:L2_LO];
   assign l1_idx = va[VA_W-1:L1_LO];
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int PA_W  = 30,
   parameter int IDX_W = 12,
   parameter int SHIFT = 2
) (
   input  logic [PA_W-1:0]  base,
   input  logic [IDX_W-1:0] idx,
   output logic [PA_W-1:0]  addr
);
   localparam int SC_W = IDX_W + SHIFT;

   logic [PA_W-1:0] scaled;

   if (SC_W >= PA_W) begin : g_bad_width
      $error("scaled index must be narrower than the physical address");
   end

   if (SHIFT == 0) begin : g_unscaled
      assign scaled = {{(PA_W-SC_W){1'b0}}, idx};
   end else begin : g_scaled
      assign scaled = {{(PA_W-SC_W){1'b0}}, idx, {SHIFT{1'b0}}};
   end

   assign addr = base + scaled;
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
   import pt_walk_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        mem_ready,
   input  logic        mem_rvalid,
   input  logic        present,
   input  logic        rsp_ready,
   output walk_state_t state,
   output logic        req_ready,
   output logic        mem_req,
   output logic        lvl2_sel,
   output logic        rsp_valid,
   output logic        cap_va,
   output logic        cap_l1,
   output logic        cap_l2,
   output logic        set_fault
);
   walk_state_t nxt;

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE:    if (req_valid) nxt = ST_L1_REQ;
         ST_L1_REQ:  if (mem_ready) nxt = ST_L1_WAIT;
         ST_L1_WAIT: if (mem_rvalid) nxt = present ? ST_L2_REQ : ST_DONE;
         ST_L2_REQ:  if (mem_ready) nxt = ST_L2_WAIT;
         ST_L2_WAIT: if (mem_rvalid) nxt = ST_DONE;
         ST_DONE:    if (rsp_ready) nxt = ST_IDLE;
         default:    nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   assign req_ready = (state == ST_IDLE);
   assign rsp_valid = (state == ST_DONE);
   assign mem_req   = (state == ST_L1_REQ) || (state == ST_L2_REQ);
   assign lvl2_sel  = (state == ST_L2_REQ);
   assign cap_va    = req_ready && req_valid;
   assign cap_l1    = (state == ST_L1_WAIT) && mem_rvalid && present;
   assign cap_l2    = (state == ST_L2_WAIT) && mem_rvalid && present;
   assign set_fault = ((state == ST_L1_WAIT) || (state == ST_L2_WAIT)) && mem_rvalid && !present;

   // R4: the second-level request only follows a returned top-level read
   a_r4_l2_after_l1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lvl2_sel) |-> $past(state) == ST_L1_WAIT);

   // R9: one walk at a time
   a_r9_single_walk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!mem_req && !rsp_valid));

   // R9: response is held until it is taken
   a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> rsp_valid);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pt_walk_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int L1_W   = 12,
   parameter int L2_W   = 8,
   parameter int OFF_W  = 12,
   parameter int PA_W   = 30,
   parameter int ENT_W  = 32,
   parameter int PPN_W  = 18,
   parameter int PRES_B = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             root_we,
   input  logic [PA_W-1:0]  root_wdata,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_va,
   output logic             rsp_valid,
   input  logic             rsp_ready,
   output logic [PA_W-1:0]  rsp_pa,
   output logic             rsp_fault,
   output logic             mem_req,
   input  logic             mem_ready,
   output logic [PA_W-1:0]  mem_addr,
   input  logic             mem_rvalid,
   input  logic [ENT_W-1:0] mem_rdata
);
   localparam int SHIFT = $clog2(ENT_W / 8);

   if (PPN_W + OFF_W != PA_W) begin : g_bad_pa
      $error("page number plus offset must fill the physical address");
   end
   if (PRES_B >= ENT_W || PA_W > PRES_B || PPN_W > PRES_B) begin : g_bad_entry
      $error("present flag must sit above the address fields of an entry");
   end

   walk_state_t      state;
   logic             lvl2_sel, cap_va, cap_l1, cap_l2, set_fault;
   logic [VA_W-1:0]  va_q;
   logic [PA_W-1:0]  root_q, l2_base_q, l1_addr, l2_addr;
   logic [PPN_W-1:0] ppn_q;
   logic             fault_q;
   logic [L1_W-1:0]  l1_idx;
   logic [L2_W-1:0]  l2_idx;
   logic [OFF_W-1:0] offset;
   logic             unused_bits;

   assign unused_bits = ^mem_rdata;

   ptw_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .mem_ready (mem_ready),
      .mem_rvalid(mem_rvalid),
      .present   (mem_rdata[PRES_B]),
      .rsp_ready (rsp_ready),
      .state     (state),
      .req_ready (req_ready),
      .mem_req   (mem_req),
      .lvl2_sel  (lvl2_sel),
      .rsp_valid (rsp_valid),
      .cap_va    (cap_va),
      .cap_l1    (cap_l1),
      .cap_l2    (cap_l2),
      .set_fault (set_fault)
   );

   ptw_field_split #(.VA_W(VA_W), .L1_W(L1_W), .L2_W(L2_W), .OFF_W(OFF_W)) u_split (
      .va    (va_q),
      .l1_idx(l1_idx),
      .l2_idx(l2_idx),
      .offset(offset)
   );

   ptw_addr_gen #(.PA_W(PA_W), .IDX_W(L1_W), .SHIFT(SHIFT)) u_l1_addr (
      .base(root_q),
      .idx (l1_idx),
      .addr(l1_addr)
   );

   ptw_addr_gen #(.PA_W(PA_W), .IDX_W(L2_W), .SHIFT(SHIFT)) u_l2_addr (
      .base(l2_base_q),
      .idx (l2_idx),
      .addr(l2_addr)
   );

   assign mem_addr = lvl2_sel ? l2_addr : l1_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         root_q    <= '0;
         va_q      <= '0;
         l2_base_q <= '0;
         ppn_q     <= '0;
         fault_q   <= 1'b0;
      end else begin
         if (root_we && state == ST_IDLE) root_q <= root_wdata;
         if (cap_va) begin
            va_q    <= req_va;
            ppn_q   <= '0;
            fault_q <= 1'b0;
         end
         if (cap_l1)    l2_base_q <= mem_rdata[PA_W-1:0];
         if (cap_l2)    ppn_q     <= mem_rdata[PPN_W-1:0];
         if (set_fault) fault_q   <= 1'b1;
      end
   end

   assign rsp_pa    = {ppn_q, offset};
   assign rsp_fault = fault_q;

   // R8: address phase is held until accepted
   a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

   // R10: root pointer is frozen while a walk runs
   a_r10_root_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |=> $stable(root_q));

   // R5: the page offset passes through untranslated
   a_r5_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_pa[OFF_W-1:0] == va_q[OFF_W-1:0]);

   // R9: the response does not change while it waits
   a_r9_rsp_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> ($stable(rsp_pa) && $stable(rsp_fault)));
endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        root_we = 1'b0;
   logic [29:0] root_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_va = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [29:0] rsp_pa;
   logic        rsp_fault;
   logic        mem_req;
   logic        mem_ready = 1'b0;
   logic [29:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;

   int n_checks = 0;
   int n_fail = 0;
   logic [29:0] root_model = '0;

   always #2 clk = ~clk;

   pt_walker i_pt_walker (
      .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_wdata(root_wdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
      .mem_req(mem_req), .mem_ready(mem_ready), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   function automatic logic [29:0] f_l1_addr(logic [29:0] root, logic [31:0] va);
      return root + {16'd0, va[31:20], 2'b00};
   endfunction
   function automatic logic [29:0] f_l2_addr(logic [31:0] ent, logic [31:0] va);
      return ent[29:0] + {20'd0, va[19:12], 2'b00};
   endfunction
   function automatic logic [29:0] f_pa(logic [31:0] ent, logic [31:0] va);
      return {ent[17:0], va[11:0]};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   task automatic write_root(input logic [29:0] v);
      @(negedge clk);
      root_we = 1'b1; root_wdata = v;
      @(negedge clk);
      root_we = 1'b0; root_wdata = $urandom;
      root_model = v;
   endtask

   task automatic serve(input logic [29:0] exp_addr, input logic [31:0] data, input string req);
      int guard = 0;
      while (!mem_req && guard < 40) begin
         @(negedge clk);
         guard++;
      end
      chk(mem_req, req, "read requested", {31'd0, mem_req}, 32'd1);
      chk(mem_addr == exp_addr, req, "read address", {2'b0, mem_addr}, {2'b0, exp_addr});
      repeat ($urandom % 3) begin
         @(negedge clk);
         chk(mem_req && mem_addr == exp_addr, "R8", "held request", {2'b0, mem_addr}, {2'b0, exp_addr});
      end
      mem_ready = 1'b1;
      @(negedge clk);
      mem_ready = 1'b0;
      repeat ($urandom % 3) begin
         chk(!mem_req, "R4", "no read before data", {31'd0, mem_req}, 32'd0);
         @(negedge clk);
      end
      mem_rvalid = 1'b1; mem_rdata = data;
      @(negedge clk);
      mem_rvalid = 1'b0; mem_rdata = $urandom;
   endtask

   task automatic walk(input logic [31:0] va, input logic [31:0] e1, input logic [31:0] e2,
                       input bit mid_root_write);
      int guard = 0;
      bit exp_fault;
      @(negedge clk);
      chk(req_ready, "R9", "idle before request", {31'd0, req_ready}, 32'd1);
      req_valid = 1'b1; req_va = va;
      @(negedge clk);
      req_valid = 1'b0; req_va = $urandom;
      chk(!req_ready, "R9", "busy during walk", {31'd0, req_ready}, 32'd0);
      if (mid_root_write) begin
         root_we = 1'b1; root_wdata = ~root_model;
         @(negedge clk);
         root_we = 1'b0;
      end
      serve(f_l1_addr(root_model, va), e1, mid_root_write ? "R10" : "R3");
      if (e1[31]) serve(f_l2_addr(e1, va), e2, "R4");
      while (!rsp_valid && guard < 20) begin
         chk(!mem_req, "R6", "no extra read", {31'd0, mem_req}, 32'd0);
         @(negedge clk);
         guard++;
      end
      exp_fault = !e1[31] || !e2[31];
      chk(rsp_valid, "R9", "response present", {31'd0, rsp_valid}, 32'd1);
      chk(rsp_fault == exp_fault, !e1[31] ? "R6" : (!e2[31] ? "R7" : "R5"), "fault flag",
          {31'd0, rsp_fault}, {31'd0, exp_fault});
      if (!exp_fault)
         chk(rsp_pa == f_pa(e2, va), "R5", "physical address", {2'b0, rsp_pa}, {2'b0, f_pa(e2, va)});
      repeat ($urandom % 3) begin
         @(negedge clk);
         chk(rsp_valid && !req_ready, "R9", "response held", {31'd0, rsp_valid}, 32'd1);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(req_ready && !rsp_valid, "R9", "idle after accept", {31'd0, req_ready}, 32'd1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL R9 watchdog expired: actual hung expected done");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R1: reset values
      chk(req_ready && !rsp_valid && !mem_req, "R1", "in reset", {29'd0, req_ready, rsp_valid, mem_req}, 32'h4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_req, "R1", "after reset", {29'd0, req_ready, rsp_valid, mem_req}, 32'h4);

      // R2: distinct field values at every boundary
      write_root(30'h0010_0000);
      walk(32'hABC_5D_123, 32'h8000_4000, 32'h8002_468A, 1'b0);
      walk(32'h0000_0000, 32'h8000_0000, 32'h8000_0000, 1'b0);
      walk(32'hFFFF_FFFF, 32'hBFFF_FFFC, 32'hC003_FFFF, 1'b0);
      // R3: root near the top wraps modulo 2^30
      write_root(30'h3FFF_FFF0);
      walk(32'h0100_2000, 32'h8123_4560, 32'h8001_1111, 1'b0);
      // R6 and R7: missing entries
      walk(32'h1234_5678, 32'h7FFF_FFFF, 32'h8000_0001, 1'b0);
      walk(32'h8765_4321, 32'h8000_1000, 32'h0003_FFFF, 1'b0);
      // R10: root write during a walk is dropped, later walk still uses old root
      write_root(30'h0234_5678);
      walk(32'h4444_4444, 32'h8111_1110, 32'h8000_2222, 1'b1);
      walk(32'h0001_1000, 32'h8000_0100, 32'h8000_0003, 1'b0);

      for (int i = 0; i < 60; i++) begin
         logic [31:0] e1, e2;
         if (i % 10 == 0) write_root($urandom);
         e1 = $urandom; e2 = $urandom;
         e1[31] = ($urandom % 8) != 0;
         e2[31] = ($urandom % 8) != 0;
         walk($urandom, e1, e2, ($urandom % 6) == 0);
      end
      finish_run();
   end
endmodule